// File: doc/BRIEF.md
# Grouped MSI Capture Interrupt Controller

This block sits beside a root-port transaction layer. It watches inbound posted memory writes, which carry a 64-bit address and 32 bits of data. When a write lands on one of eight programmable capture addresses, the block turns the data word into a pending bit for one of 32 vectors in that group. This gives 256 message-signalled vectors in all.

Each group condenses into one summary bit of a shared top-level status word. Four emulated level-sensitive legacy lines sit in the same word. They are driven by per-line assert and deassert pulses from the message decoder.

Software services an interrupt in two steps. It first reads the shared word and then the pending word of each flagged group. Both levels clear by writing ones. The single interrupt output is the OR of every enabled top-level status bit, and it is registered.

Top module: `msi_intc`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_out` is 0.
- R2: Group i has its capture address low word at 0xC00+0x10*i and its high word at 0xC80+4*i. A write whose 64-bit address equals {high,low} and whose data d is below 32 sets pending bit d at 0xC04+0x10*i one cycle later. No other group changes.
- R3: An inbound write whose data is 32 or more is ignored. A write whose address differs from a capture address in either word is also ignored.
- R4: Writing ones to a group's pending word clears those bits. A capture arriving in the same cycle still sets its bit.
- R5: Summary bit 8+i of the status word at 0x184 sets only when group-enable bit i at 0x190 is 1 and some pending bit of the group is also set in the vector-enable word at 0xC08+0x10*i.
- R6: A summary bit stays set after its vectors are cleared, until a one is written to it. The write clears it for one cycle, and it sets again on the next cycle if the condition of R5 still holds.
- R7: Legacy line j (A..D as 0..3) sets status bit 24+j on an assert pulse. Writing a one to that bit has no effect while the line is asserted. After the deassert pulse the bit stays set until a one is written to it.
- R8: `irq_out` goes high one cycle after any status bit and the matching bit of the enable word at 0x180 are both 1.
- R9: Only bits 15:8 and 27:24 of the enable word at 0x180, and only bits 7:0 of the group-enable word at 0x190, hold written values. All other bits read 0.
- R10: `reg_rdata` shows the register addressed in the previous cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mw_valid | input | 1 | Inbound posted write strobe |
| mw_addr | input | 64 | Inbound write address |
| mw_data | input | 32 | Inbound write data |
| intx_assert | input | 4 | Per-line assert pulses |
| intx_deassert | input | 4 | Per-line deassert pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The hardest case to reach is the one-cycle gap in R6. It only appears when a summary bit is cleared while its group still has an enabled pending vector. The bench first leaves a vector pending and then writes the clear. It issues two back-to-back reads of the status word: the first must see the bit low and the second must see it high again. A similar squeeze targets R4: a capture and a one-write to the same pending word are driven in the same cycle, and the captured bit must survive while the other bit is cleared.

// File: rtl/msi_intc_pkg.sv
`timescale 1ns/1ps
package msi_intc_pkg;
  // Top-level words
  localparam int unsigned TOP_EN_OFS    = 'h180;
  localparam int unsigned TOP_ST_OFS    = 'h184;
  localparam int unsigned GRP_EN_OFS    = 'h190;
  // Per-group windows
  localparam int unsigned GRP_BASE      = 'hC00;
  localparam int unsigned GRP_STRIDE    = 'h10;
  localparam int unsigned CAP_LO_OFS    = 'h0;
  localparam int unsigned PEND_OFS      = 'h4;
  localparam int unsigned VEN_OFS       = 'h8;
  localparam int unsigned CAP_HI_BASE   = 'hC80;
  localparam int unsigned CAP_HI_STRIDE = 'h4;
  // Field positions in the top-level words
  localparam int unsigned SUM_LSB       = 8;
  localparam int unsigned INTX_LSB      = 24;
endpackage

// File: rtl/msi_set_unit.sv
`timescale 1ns/1ps
module msi_set_unit #(
  parameter int VEC     = 32,
  parameter int DATA_W  = 32,
  parameter int MADDR_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mw_valid,
  input  logic [MADDR_W-1:0] mw_addr,
  input  logic [DATA_W-1:0]  mw_data,
  input  logic               lo_we,
  input  logic               hi_we,
  input  logic               pend_we,
  input  logic               ven_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [MADDR_W-1:0] cap_addr,
  output logic [VEC-1:0]     pend,
  output logic [VEC-1:0]     ven,
  output logic               active
);
  localparam int IDX_W = $clog2(VEC);
  localparam int HI_W  = MADDR_W - DATA_W;

  logic           hit;
  logic [VEC-1:0] hot;
  logic [VEC-1:0] pend_d;

  assign hit = mw_valid && (mw_addr == cap_addr) && (mw_data < DATA_W'(VEC));
  assign hot = hit ? (VEC'(1) << mw_data[IDX_W-1:0]) : '0;

  always_comb begin
    pend_d = pend;
    if (pend_we) pend_d = pend & ~wdata[VEC-1:0];
    pend_d = pend_d | hot;  // capture wins over clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      pend     <= '0;
      ven      <= '0;
    end else begin
      if (lo_we)  cap_addr[DATA_W-1:0]       <= wdata;
      if (hi_we)  cap_addr[MADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (ven_we) ven <= wdata[VEC-1:0];
      pend <= pend_d;
    end
  end

  assign active = |(pend & ven);
endmodule

// File: rtl/intx_unit.sv
`timescale 1ns/1ps
module intx_unit #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] assert_i,
  input  logic [N-1:0] deassert_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] level,
  output logic [N-1:0] status
);
  logic [N-1:0] level_d;
  logic [N-1:0] clr_eff;

  assign level_d = (level & ~deassert_i) | assert_i;
  // a clear is honoured only for lines already deasserted
  assign clr_eff = clr_we ? (clr_mask & ~level) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      level  <= '0;
      status <= '0;
    end else begin
      level  <= level_d;
      status <= (status & ~clr_eff) | level_d;
    end
  end
endmodule

// File: rtl/msi_intc.sv
`timescale 1ns/1ps
module msi_intc #(
  parameter int NUM_SETS    = 8,
  parameter int VEC_PER_SET = 32,
  parameter int NUM_INTX    = 4,
  parameter int DATA_W      = 32,
  parameter int MADDR_W     = 64,
  parameter int RADDR_W     = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mw_valid,
  input  logic [MADDR_W-1:0] mw_addr,
  input  logic [DATA_W-1:0]  mw_data,
  input  logic [NUM_INTX-1:0] intx_assert,
  input  logic [NUM_INTX-1:0] intx_deassert,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_out
);
  import msi_intc_pkg::*;

  localparam logic [DATA_W-1:0] EN_MASK =
      (DATA_W'({NUM_SETS{1'b1}}) << SUM_LSB) | (DATA_W'({NUM_INTX{1'b1}}) << INTX_LSB);

  logic [MADDR_W-1:0]     cap_a  [NUM_SETS];
  logic [VEC_PER_SET-1:0] pend_a [NUM_SETS];
  logic [VEC_PER_SET-1:0] ven_a  [NUM_SETS];
  logic [NUM_SETS-1:0]    grp_active;
  logic [NUM_SETS-1:0]    lo_we, hi_we, pend_we, ven_we;

  logic [DATA_W-1:0]   top_en_q;
  logic [NUM_SETS-1:0] grp_en_q;
  logic [NUM_SETS-1:0] sum_q;
  logic [NUM_SETS-1:0] sum_clr;
  logic                st_we;
  logic [NUM_INTX-1:0] intx_level, intx_st;
  logic [DATA_W-1:0]   top_status;
  logic [DATA_W-1:0]   rd_d;

  logic [NUM_SETS*MADDR_W-1:0]     all_cap;
  logic [NUM_SETS*VEC_PER_SET-1:0] all_pend;

  // ---------------- write decode ----------------
  always_comb begin
    for (int i = 0; i < NUM_SETS; i++) begin
      lo_we[i]   = reg_we && (reg_addr == RADDR_W'(GRP_BASE + i*GRP_STRIDE + CAP_LO_OFS));
      pend_we[i] = reg_we && (reg_addr == RADDR_W'(GRP_BASE + i*GRP_STRIDE + PEND_OFS));
      ven_we[i]  = reg_we && (reg_addr == RADDR_W'(GRP_BASE + i*GRP_STRIDE + VEN_OFS));
      hi_we[i]   = reg_we && (reg_addr == RADDR_W'(CAP_HI_BASE + i*CAP_HI_STRIDE));
    end
  end

  assign st_we   = reg_we && (reg_addr == RADDR_W'(TOP_ST_OFS));
  assign sum_clr = st_we ? reg_wdata[SUM_LSB +: NUM_SETS] : '0;

  // ---------------- per-group capture ----------------
  for (genvar g = 0; g < NUM_SETS; g++) begin : g_grp
    msi_set_unit #(
      .VEC(VEC_PER_SET), .DATA_W(DATA_W), .MADDR_W(MADDR_W)
    ) u_grp (
      .clk(clk), .rst(rst),
      .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
      .lo_we(lo_we[g]), .hi_we(hi_we[g]), .pend_we(pend_we[g]), .ven_we(ven_we[g]),
      .wdata(reg_wdata),
      .cap_addr(cap_a[g]), .pend(pend_a[g]), .ven(ven_a[g]),
      .active(grp_active[g])
    );
    assign all_cap[g*MADDR_W +: MADDR_W]          = cap_a[g];
    assign all_pend[g*VEC_PER_SET +: VEC_PER_SET] = pend_a[g];
  end

  // ---------------- legacy lines ----------------
  intx_unit #(.N(NUM_INTX)) u_intx (
    .clk(clk), .rst(rst),
    .assert_i(intx_assert), .deassert_i(intx_deassert),
    .clr_we(st_we), .clr_mask(reg_wdata[INTX_LSB +: NUM_INTX]),
    .level(intx_level), .status(intx_st)
  );

  assign top_status = (DATA_W'(sum_q) << SUM_LSB) | (DATA_W'(intx_st) << INTX_LSB);

  // ---------------- top-level registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      top_en_q <= '0;
      grp_en_q <= '0;
      sum_q    <= '0;
      irq_out  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RADDR_W'(TOP_EN_OFS)) top_en_q <= reg_wdata & EN_MASK;
      if (reg_we && reg_addr == RADDR_W'(GRP_EN_OFS)) grp_en_q <= reg_wdata[NUM_SETS-1:0];
      for (int i = 0; i < NUM_SETS; i++) begin
        if (sum_clr[i])                         sum_q[i] <= 1'b0;
        else if (grp_en_q[i] && grp_active[i])  sum_q[i] <= 1'b1;
      end
      irq_out <= |(top_status & top_en_q);
    end
  end

  // ---------------- registered read ----------------
  always_comb begin
    rd_d = '0;
    if (reg_addr == RADDR_W'(TOP_EN_OFS)) rd_d = top_en_q;
    if (reg_addr == RADDR_W'(TOP_ST_OFS)) rd_d = top_status;
    if (reg_addr == RADDR_W'(GRP_EN_OFS)) rd_d = DATA_W'(grp_en_q);
    for (int i = 0; i < NUM_SETS; i++) begin
      if (reg_addr == RADDR_W'(GRP_BASE + i*GRP_STRIDE + CAP_LO_OFS)) rd_d = cap_a[i][DATA_W-1:0];
      if (reg_addr == RADDR_W'(GRP_BASE + i*GRP_STRIDE + PEND_OFS))   rd_d = DATA_W'(pend_a[i]);
      if (reg_addr == RADDR_W'(GRP_BASE + i*GRP_STRIDE + VEN_OFS))    rd_d = DATA_W'(ven_a[i]);
      if (reg_addr == RADDR_W'(CAP_HI_BASE + i*CAP_HI_STRIDE))        rd_d = DATA_W'(cap_a[i][MADDR_W-1:DATA_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/msi_intc_checker.sv
`timescale 1ns/1ps
module msi_intc_checker #(
  parameter int NUM_SETS    = 8,
  parameter int VEC_PER_SET = 32,
  parameter int NUM_INTX    = 4,
  parameter int DATA_W      = 32,
  parameter int MADDR_W     = 64
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            mw_valid,
  input logic [MADDR_W-1:0]              mw_addr,
  input logic [DATA_W-1:0]               mw_data,
  input logic                            reg_we,
  input logic [NUM_SETS*MADDR_W-1:0]     all_cap,
  input logic [NUM_SETS*VEC_PER_SET-1:0] all_pend,
  input logic [NUM_SETS-1:0]             grp_en,
  input logic [NUM_SETS-1:0]             grp_active,
  input logic [NUM_SETS-1:0]             sum_clr,
  input logic [NUM_SETS-1:0]             sum_q,
  input logic [NUM_INTX-1:0]             intx_level,
  input logic [NUM_INTX-1:0]             intx_st,
  input logic [DATA_W-1:0]               top_status,
  input logic [DATA_W-1:0]               top_en,
  input logic                            irq_out
);
  localparam int IDX_W = $clog2(VEC_PER_SET);

  logic [VEC_PER_SET-1:0] hot;
  assign hot = VEC_PER_SET'(1) << mw_data[IDX_W-1:0];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_cap
    // R2: a matching capture shows up in the group's pending word
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
      (mw_valid && mw_addr == all_cap[g*MADDR_W +: MADDR_W] && mw_data < DATA_W'(VEC_PER_SET))
      |=> ((all_pend[g*VEC_PER_SET +: VEC_PER_SET] & $past(hot)) != '0));
  end

  p_bad_data_r3: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && mw_data >= DATA_W'(VEC_PER_SET) && !reg_we) |=> $stable(all_pend));

  p_sum_set_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(grp_en & grp_active & ~sum_clr) & ~sum_q) == '0));

  p_sum_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (sum_clr != '0) |=> ((sum_q & $past(sum_clr)) == '0));

  p_intx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((intx_level & ~intx_st) == '0));

  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(top_status & top_en))));
endmodule

bind msi_intc msi_intc_checker #(
  .NUM_SETS(NUM_SETS), .VEC_PER_SET(VEC_PER_SET), .NUM_INTX(NUM_INTX),
  .DATA_W(DATA_W), .MADDR_W(MADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
  .reg_we(reg_we), .all_cap(all_cap), .all_pend(all_pend),
  .grp_en(grp_en_q), .grp_active(grp_active), .sum_clr(sum_clr), .sum_q(sum_q),
  .intx_level(intx_level), .intx_st(intx_st), .top_status(top_status),
  .top_en(top_en_q), .irq_out(irq_out)
);

// File: tb/msi_intc_test.sv
`timescale 1ns/1ps
module msi_intc_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        mw_valid;
  logic [63:0] mw_addr;
  logic [31:0] mw_data;
  logic [3:0]  intx_assert, intx_deassert;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  msi_intc uut (
    .clk(clk), .rst(rst), .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
    .intx_assert(intx_assert), .intx_deassert(intx_deassert),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [63:0] cap(input int i);
    return {32'(32'h10 + i), 32'(32'hFEE0_0000 + i * 16)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    mw_addr = a; mw_data = d; mw_valid = 1'b1;
    @(negedge clk);
    mw_valid = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] as, input logic [3:0] de);
    intx_assert = as; intx_deassert = de;
    @(negedge clk);
    intx_assert = '0; intx_deassert = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; mw_valid = 0; mw_addr = '0; mw_data = '0;
    intx_assert = '0; intx_deassert = '0;
    reg_we = 0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", irq_out, 0);
    rchk("R1 top status", 12'h184, 0);
    rchk("R1 top enable", 12'h180, 0);
    rchk("R1 group enable", 12'h190, 0);
    rchk("R1 group3 cap lo", 12'hC30, 0);
    rchk("R1 group7 pending", 12'hC74, 0);
    rchk("R10 unmapped", 12'h004, 0);

    // R2 program and read back capture addresses
    for (int i = 0; i < 8; i++) begin
      wr(12'(12'hC00 + i * 16), cap(i)[31:0]);
      wr(12'(12'hC80 + i * 4), cap(i)[63:32]);
    end
    for (int i = 0; i < 8; i++) begin
      rchk("R2 cap lo", 12'(12'hC00 + i * 16), cap(i)[31:0]);
      rchk("R2 cap hi", 12'(12'hC80 + i * 4), cap(i)[63:32]);
    end

    // R2/R4 exhaustive sweep of all 256 vectors
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 32; v++) begin
        msi(cap(i), v);
        rchk("R2 pending bit", 12'(12'hC04 + i * 16), 32'(1) << v);
        rchk("R2 other group", 12'(12'hC04 + ((i + 1) % 8) * 16), 0);
        wr(12'(12'hC04 + i * 16), 32'(1) << v);
        rchk("R4 cleared", 12'(12'hC04 + i * 16), 0);
      end
    end
    rchk("R5 no summary while groups disabled", 12'h184, 0);

    // R3 ignored writes
    msi(cap(2), 32);
    msi(cap(2), 32'hFFFF_FFFF);
    msi({cap(2)[63:32] + 32'd1, cap(2)[31:0]}, 5);
    msi({cap(2)[63:32], cap(2)[31:0] + 32'd4}, 5);
    rchk("R3 group2 untouched", 12'hC24, 0);

    // R4 capture and clear in the same cycle
    msi(cap(1), 3);
    mw_addr = cap(1); mw_data = 7; mw_valid = 1'b1;
    reg_addr = 12'hC14; reg_wdata = 32'h88; reg_we = 1'b1;
    @(negedge clk);
    mw_valid = 1'b0; reg_we = 1'b0;
    rchk("R4 capture beats clear", 12'hC14, 32'h80);
    wr(12'hC14, 32'hFFFF_FFFF);
    rchk("R4 full clear", 12'hC14, 0);

    // R5 gating by vector enable and group enable
    wr(12'hC58, 32'h0000_00F0);
    wr(12'hC68, 32'hFFFF_FFFF);
    rchk("R9 vector enable readback", 12'hC58, 32'hF0);
    wr(12'h190, 32'hABCD_0020);
    rchk("R9 group enable width", 12'h190, 32'h20);
    msi(cap(5), 2);
    idle(2);
    rchk("R5 masked vector", 12'h184, 0);
    msi(cap(6), 1);
    idle(2);
    rchk("R5 disabled group", 12'h184, 0);
    msi(cap(5), 4);
    idle(2);
    rchk("R5 group5 summary", 12'h184, 32'h2000);
    wr(12'h190, 32'h60);
    idle(2);
    rchk("R5 group6 summary", 12'h184, 32'h6000);

    // R6 clear with condition still true, then sticky behaviour
    wr(12'h184, 32'h2000);
    rchk("R6 cleared one cycle", 12'h184, 32'h4000);
    rchk("R6 set again", 12'h184, 32'h6000);
    wr(12'hC54, 32'h14);
    rchk("R4 group5 cleared", 12'hC54, 0);
    idle(2);
    rchk("R6 summary sticky", 12'h184, 32'h6000);
    wr(12'hC64, 32'h2);
    wr(12'h184, 32'h6000);
    idle(2);
    rchk("R6 summary gone", 12'h184, 0);

    // R7 legacy line B
    pulse(4'b0010, 4'b0000);
    rchk("R7 line B set", 12'h184, 32'h0200_0000);
    wr(12'h184, 32'h0200_0000);
    idle(1);
    rchk("R7 clear ignored while asserted", 12'h184, 32'h0200_0000);
    pulse(4'b0000, 4'b0010);
    idle(1);
    rchk("R7 sticky after deassert", 12'h184, 32'h0200_0000);
    wr(12'h184, 32'h0200_0000);
    rchk("R7 cleared after deassert", 12'h184, 0);
    pulse(4'b1000, 4'b0000);
    pulse(4'b0000, 4'b1000);
    rchk("R7 line D latched", 12'h184, 32'h0800_0000);
    wr(12'h184, 32'h0800_0000);
    rchk("R7 line D cleared", 12'h184, 0);

    // R8 / R9 interrupt output
    pulse(4'b0001, 4'b0000);
    idle(2);
    chk("R8 irq masked", irq_out, 0);
    wr(12'h180, 32'hFFFF_FFFF);
    chk("R8 irq one cycle later", irq_out, 0);
    @(negedge clk);
    chk("R8 irq raised", irq_out, 1);
    rchk("R9 enable writable bits", 12'h180, 32'h0F00_FF00);
    pulse(4'b0000, 4'b0001);
    wr(12'h184, 32'h0100_0000);
    idle(2);
    chk("R8 irq dropped", irq_out, 0);
    msi(cap(5), 4);
    idle(2);
    chk("R8 irq from group", irq_out, 1);
    rchk("R10 unmapped after traffic", 12'h1FC, 0);

    finish_run();
  end
endmodule